// File: doc/BRIEF.md
# Two-Stage Instruction Fetch and Program Counter Unit

This unit is the front end of a small Harvard-style 8-bit controller. It owns the program counter and drives the address and enable of a synchronous program memory port. The memory returns one 14-bit word per instruction cycle. The memory's output register acts as the fetched-instruction slot, so the next word is read while execute works on the current one.

Execute can ask the unit to move the program counter to a new address, for example on a taken branch, a jump, a call or a return. A separate request loads the fixed interrupt entry address. Either request throws away the word already in flight, and execute sees one empty slot in its place. That empty slot is why every control-flow instruction takes two cycles. A stall input freezes the counter and the slot.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `imem_addr_o` = 0x0000, `ir_valid_o` = 0 and `ir_word_o` = 0.
- R2: In a cycle with no reset, stall, redirect or vector request, the next cycle shows `imem_addr_o` one higher than before. In that next cycle the slot holds the word stored at the old address, with `ir_valid_o` = 1 and `ir_pc_o` equal to the old address. The word comes back from memory one cycle after the address is presented.
- R3: A redirect request (`redir_i` = 1, `vec_i` = 0) makes the next cycle present `redir_addr_i` on `imem_addr_o`, with an empty slot. One cycle later the word at the target is valid, with `ir_pc_o` equal to the target.
- R4: A vector request (`vec_i` = 1) makes the next cycle present address 0x0004, with an empty slot.
- R5: When `vec_i` and `redir_i` are both high, the vector address wins and the redirect target is ignored.
- R6: A stall (`stall_i` = 1 with no redirect or vector request) holds `imem_addr_o`, `ir_word_o`, `ir_valid_o` and `ir_pc_o` unchanged in the next cycle.
- R7: A redirect or vector request in the same cycle as a stall is carried out as if no stall were present.
- R8: The 15-bit program counter wraps from 0x7FFF to 0x0000 when it steps.
- R9: Whenever `ir_valid_o` is 0, `ir_word_o` is all zeros. This all-zero word is the no-op bubble.
- R10: `imem_en_o` is 1 exactly when `stall_i` is 0 or a redirect or vector request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze the counter and the fetched slot |
| redir_i | input | 1 | Redirect request from execute |
| redir_addr_i | input | 15 | Redirect target address |
| vec_i | input | 1 | Load the interrupt entry address |
| imem_en_o | output | 1 | Program memory read enable |
| imem_addr_o | output | 15 | Program memory word address (the program counter) |
| imem_data_i | input | 14 | Registered read data from program memory |
| ir_word_o | output | 14 | Word handed to execute; zero when the slot is empty |
| ir_valid_o | output | 1 | Slot holds a real instruction |
| ir_pc_o | output | 15 | Address of the word in the slot |

## Verification
A corrupt program counter shows up on `imem_addr_o` in the very next cycle. One cycle after that it reaches `ir_pc_o` and the word contents. A slot-valid flag that misses a flush lets a wrong-path word through with `ir_valid_o` high. That is visible in the cycle right after the redirect. Stall and priority faults are exposed by comparing each cycle against an independent reference model driven with random mixes of stall, redirect, vector and reset. Directed cases cover simultaneous requests and the address wrap.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  // Action chosen for the coming clock edge, highest priority first in fetch_ctrl.
  typedef enum logic [1:0] {
    FA_STEP   = 2'd0,
    FA_HOLD   = 2'd1,
    FA_JUMP   = 2'd2,
    FA_VECTOR = 2'd3
  } fetch_act_e;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic       stall_i,
  input  logic       redir_i,
  input  logic       vec_i,
  output fetch_act_e act_o,
  output logic       flush_o,
  output logic       mem_en_o
);
  // Vector over redirect, either flush over stall.
  always_comb begin
    if (vec_i)        act_o = FA_VECTOR;
    else if (redir_i) act_o = FA_JUMP;
    else if (stall_i) act_o = FA_HOLD;
    else              act_o = FA_STEP;
  end

  assign flush_o  = (act_o == FA_VECTOR) || (act_o == FA_JUMP);
  assign mem_en_o = (act_o != FA_HOLD);
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
  import fetch_pkg::*;
#(
  parameter int unsigned PC_W        = 15,
  parameter int unsigned RESET_ADDR  = 0,
  parameter int unsigned VECTOR_ADDR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  fetch_act_e      act_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] PC_RST = PC_W'(RESET_ADDR);
  localparam logic [PC_W-1:0] PC_VEC = PC_W'(VECTOR_ADDR);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    unique case (act_i)
      FA_VECTOR: pc_d = PC_VEC;
      FA_JUMP:   pc_d = target_i;
      FA_HOLD:   pc_d = pc_q;
      default:   pc_d = pc_q + PC_ONE;  // wraps naturally at PC_W bits
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= PC_RST;
    else     pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/fetch_slot.sv
module fetch_slot
  import fetch_pkg::*;
#(
  parameter int unsigned PC_W   = 15,
  parameter int unsigned WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  fetch_act_e        act_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  input  logic [WORD_W-1:0] mem_word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam logic [WORD_W-1:0] NOP_WORD = '0;

  logic            valid_q;
  logic [PC_W-1:0] pc_q;

  // The memory output register is the data half of the slot; this keeps its tag.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
    end else begin
      unique case (act_i)
        FA_STEP: begin
          valid_q <= 1'b1;
          pc_q    <= fetch_pc_i;
        end
        FA_HOLD: begin
          valid_q <= valid_q;
          pc_q    <= pc_q;
        end
        default: begin
          valid_q <= 1'b0;
          pc_q    <= pc_q;
        end
      endcase
    end
  end

  assign valid_o = valid_q;
  assign pc_o    = pc_q;
  assign word_o  = valid_q ? mem_word_i : NOP_WORD;
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int unsigned PC_W        = 15,
  parameter int unsigned WORD_W      = 14,
  parameter int unsigned RESET_ADDR  = 0,
  parameter int unsigned VECTOR_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              redir_i,
  input  logic [PC_W-1:0]   redir_addr_i,
  input  logic              vec_i,
  output logic              imem_en_o,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [WORD_W-1:0] imem_data_i,
  output logic [WORD_W-1:0] ir_word_o,
  output logic              ir_valid_o,
  output logic [PC_W-1:0]   ir_pc_o
);
  fetch_act_e      act;
  logic            flush;
  logic [PC_W-1:0] pc;

  fetch_ctrl u_ctrl (
    .stall_i  (stall_i),
    .redir_i  (redir_i),
    .vec_i    (vec_i),
    .act_o    (act),
    .flush_o  (flush),
    .mem_en_o (imem_en_o)
  );

  fetch_pc_reg #(
    .PC_W        (PC_W),
    .RESET_ADDR  (RESET_ADDR),
    .VECTOR_ADDR (VECTOR_ADDR)
  ) u_pc (
    .clk      (clk),
    .rst      (rst),
    .act_i    (act),
    .target_i (redir_addr_i),
    .pc_o     (pc)
  );

  fetch_slot #(
    .PC_W   (PC_W),
    .WORD_W (WORD_W)
  ) u_slot (
    .clk        (clk),
    .rst        (rst),
    .act_i      (act),
    .fetch_pc_i (pc),
    .mem_word_i (imem_data_i),
    .word_o     (ir_word_o),
    .valid_o    (ir_valid_o),
    .pc_o       (ir_pc_o)
  );

  assign imem_addr_o = pc;
endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
  parameter int unsigned PC_W        = 15,
  parameter int unsigned WORD_W      = 14,
  parameter int unsigned RESET_ADDR  = 0,
  parameter int unsigned VECTOR_ADDR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_i,
  input logic              redir_i,
  input logic [PC_W-1:0]   redir_addr_i,
  input logic              vec_i,
  input logic              imem_en_o,
  input logic [PC_W-1:0]   imem_addr_o,
  input logic [WORD_W-1:0] ir_word_o,
  input logic              ir_valid_o,
  input logic [PC_W-1:0]   ir_pc_o
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (imem_addr_o == PC_W'(RESET_ADDR)) && !ir_valid_o);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !redir_i && !vec_i) |=>
      (imem_addr_o == PC_W'($past(imem_addr_o) + PC_W'(1))) && ir_valid_o
      && (ir_pc_o == $past(imem_addr_o)));

  p_redirect_r3: assert property (@(posedge clk) disable iff (rst)
    (redir_i && !vec_i) |=> (imem_addr_o == $past(redir_addr_i)) && !ir_valid_o);

  p_vector_r4_r5: assert property (@(posedge clk) disable iff (rst)
    vec_i |=> (imem_addr_o == PC_W'(VECTOR_ADDR)) && !ir_valid_o);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !redir_i && !vec_i) |=>
      $stable(imem_addr_o) && $stable(ir_valid_o) && $stable(ir_pc_o));

  p_bubble_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !ir_valid_o |-> (ir_word_o == '0));

  p_enable_r10_r7: assert property (@(posedge clk) disable iff (rst)
    (redir_i || vec_i || !stall_i) |-> imem_en_o);
endmodule

bind fetch_unit fetch_unit_chk #(
  .PC_W        (PC_W),
  .WORD_W      (WORD_W),
  .RESET_ADDR  (RESET_ADDR),
  .VECTOR_ADDR (VECTOR_ADDR)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stall_i      (stall_i),
  .redir_i      (redir_i),
  .redir_addr_i (redir_addr_i),
  .vec_i        (vec_i),
  .imem_en_o    (imem_en_o),
  .imem_addr_o  (imem_addr_o),
  .ir_word_o    (ir_word_o),
  .ir_valid_o   (ir_valid_o),
  .ir_pc_o      (ir_pc_o)
);

// File: tb/tb_fetch_unit.sv
module tb_fetch_unit;
  localparam int PC_W   = 15;
  localparam int WORD_W = 14;
  localparam logic [PC_W-1:0] VEC = 15'h0004;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              stall_i = 1'b0;
  logic              redir_i = 1'b0;
  logic [PC_W-1:0]   redir_addr_i = '0;
  logic              vec_i = 1'b0;
  logic              imem_en_o;
  logic [PC_W-1:0]   imem_addr_o;
  logic [WORD_W-1:0] imem_data_i = '0;
  logic [WORD_W-1:0] ir_word_o;
  logic              ir_valid_o;
  logic [PC_W-1:0]   ir_pc_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fetch_unit dut (
    .clk(clk), .rst(rst), .stall_i(stall_i), .redir_i(redir_i),
    .redir_addr_i(redir_addr_i), .vec_i(vec_i), .imem_en_o(imem_en_o),
    .imem_addr_o(imem_addr_o), .imem_data_i(imem_data_i),
    .ir_word_o(ir_word_o), .ir_valid_o(ir_valid_o), .ir_pc_o(ir_pc_o)
  );

  // Program contents as a pure function of the address.
  function automatic logic [WORD_W-1:0] prog_word(input logic [PC_W-1:0] a);
    logic [31:0] t;
    t = {17'd0, a} * 32'd40503 ^ 32'h2A5F;
    return t[WORD_W-1:0] | 14'h0001;  // never zero, so bubbles stand out
  endfunction

  // Synchronous program memory with read enable (holds output when disabled).
  always @(posedge clk) if (imem_en_o) imem_data_i <= prog_word(imem_addr_o);

  // Reference model from the requirements.
  logic [PC_W-1:0]   e_addr;
  logic              e_valid;
  logic [PC_W-1:0]   e_pc;
  logic [WORD_W-1:0] e_word;
  string             e_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      e_addr <= '0; e_valid <= 1'b0; e_word <= '0; e_tag <= "R1";
    end else if (vec_i) begin
      e_addr <= VEC; e_valid <= 1'b0; e_word <= '0;
      e_tag <= redir_i ? "R5" : (stall_i ? "R7" : "R4");
    end else if (redir_i) begin
      e_addr <= redir_addr_i; e_valid <= 1'b0; e_word <= '0;
      e_tag <= stall_i ? "R7" : "R3";
    end else if (stall_i) begin
      e_tag <= "R6";
    end else begin
      e_pc <= e_addr; e_valid <= 1'b1; e_word <= prog_word(e_addr);
      e_addr <= e_addr + 15'd1;
      e_tag <= (e_addr == 15'h7FFF) ? "R8" : "R2";
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(imem_addr_o == e_addr, e_tag, "imem_addr", 32'(imem_addr_o), 32'(e_addr));
    chk(ir_valid_o == e_valid, e_tag, "ir_valid", 32'(ir_valid_o), 32'(e_valid));
    chk(ir_word_o == e_word, e_valid ? e_tag : "R9", "ir_word", 32'(ir_word_o), 32'(e_word));
    if (e_valid)
      chk(ir_pc_o == e_pc, e_tag, "ir_pc", 32'(ir_pc_o), 32'(e_pc));
    // R10: enable follows the inputs currently applied
    chk(imem_en_o == (!stall_i || redir_i || vec_i), "R10", "imem_en",
        32'(imem_en_o), 32'(!stall_i || redir_i || vec_i));
  endtask

  task automatic step(input bit r, input bit s, input bit j,
                      input logic [PC_W-1:0] t, input bit v);
    @(negedge clk);
    compare_all();
    rst = r; stall_i = s; redir_i = j; redir_addr_i = t; vec_i = v;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL R2 watchdog cycles=%0d expected below 100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(1, 0, 0, '0, 0);
    step(1, 0, 0, '0, 0);
    step(0, 0, 0, '0, 0);  // R1 reset state checked here
    for (int i = 0; i < 10; i++) step(0, 0, 0, '0, 0);        // R2 sequential
    step(0, 0, 1, 15'h0040, 0);                                // R3 redirect
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0, 0);
    step(0, 0, 0, '0, 1);                                      // R4 vector
    for (int i = 0; i < 3; i++) step(0, 0, 0, '0, 0);
    step(0, 0, 1, 15'h1234, 1);                                // R5 both
    for (int i = 0; i < 3; i++) step(0, 0, 0, '0, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 0, '0, 0);          // R6 stall
    step(0, 1, 1, 15'h0100, 0);                                // R7 redirect over stall
    step(0, 1, 0, '0, 0);
    step(0, 0, 0, '0, 0);
    step(0, 0, 1, 15'h7FFE, 0);                                // R8 wrap
    for (int i = 0; i < 5; i++) step(0, 0, 0, '0, 0);
    for (int i = 0; i < 3000; i++) begin
      int unsigned k;
      k = $urandom_range(0, 99);
      step(k < 1, ($urandom_range(0, 99) < 20), ($urandom_range(0, 99) < 10),
           PC_W'($urandom), ($urandom_range(0, 99) < 5));
    end
    step(0, 0, 0, '0, 0);
    step(0, 0, 0, '0, 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule